// File: doc/BRIEF.md
# Capture/Compare Channel

This block is one timer channel that either records a timer value when an external pin changes or watches a timer for a programmed value and then acts on an output pin. A 4-bit operating code picks the behaviour. A 2-bit source select picks which of several 16-bit free-running timers the channel observes. In capture operation, the asynchronous input pin passes through a synchroniser and an edge detector. An optional event divider then admits only every 4th or every 16th rising edge before the selected timer is stored. In compare operation, the channel detects the cycle on which the timer first becomes equal to a compare value. It can then toggle, set or clear its output pin, raise its flag only, or emit a one-cycle strobe that the timer uses to restart itself.

Each event sets a sticky flag, which a one-cycle clear pulse removes. The disabled code, the reserved codes and the pulse-width codes all put the channel into a quiet, cleared state.

Top module: `ccp_unit`

## Requirements
- R1: Codes 0000, 0001, 0011 and 11xx disable the channel. While such a code is applied, the flag, the output pin, the captured value, the event divider and the reset strobe are all cleared, and no pin edge or timer match has any effect.
- R2: Code 0100 stores the selected timer on each falling edge of the synchronised input and ignores rising edges.
- R3: Code 0101 stores the selected timer on each rising edge of the synchronised input. The stored value appears on `cap_val` within four clock edges after the pin changes.
- R4: Code 0110 stores the timer only on every 4th rising edge, and code 0111 only on every 16th rising edge. Edges in between are counted but ignored.
- R5: Any change of the operating code restarts the event divider count from zero.
- R6: Code 0010 inverts `out_pin` on each compare match and sets the flag.
- R7: Code 1000 drives `out_pin` low on entry, then high on a match, and sets the flag.
- R8: Code 1001 drives `out_pin` high on entry, then low on a match, and sets the flag.
- R9: Code 1010 sets the flag on a match and leaves `out_pin` unchanged.
- R10: Code 1011 sets the flag and drives `tmr_rst` high for exactly one cycle on a match. `tmr_rst` is never high in any other code.
- R11: A match is taken only on the first cycle in which the timer equals `cmp_val`. Further cycles of equality produce nothing, and the cycle in which the code changes produces no match.
- R12: The flag stays set until `clr_flag` is high at a clock edge. If an event occurs in the same cycle as the clear, the flag stays set.
- R13: `tmr_sel` = i selects timer i, which is bits [16*i+15:16*i] of `tmr_bus`, for both capture and compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 4 | Operating code |
| tmr_sel | input | SEL_W (2) | Timer source index |
| tmr_bus | input | NUM_TMR*TW (64) | Packed timer values, timer i in slice i |
| cmp_val | input | TW (16) | Compare value |
| cap_pin | input | 1 | Asynchronous capture input |
| clr_flag | input | 1 | One-cycle flag clear |
| cap_val | output | TW (16) | Last stored timer value |
| out_pin | output | 1 | Compare output pin |
| flag | output | 1 | Sticky event flag |
| tmr_rst | output | 1 | One-cycle timer restart strobe |

## Verification
Assertions check several properties on every cycle:
- the restart strobe never lasts two cycles and always comes with the flag;
- a match never repeats in back-to-back cycles;
- the set and clear compare codes leave the pin at the forced level after a match;
- the captured value holds between events;
- a disabled code keeps everything cleared;
- the flag stays set until it is cleared.

Only the bench scenarios can show that the event divider admits exactly every 4th or 16th edge and restarts when the code changes. The same holds for falling-edge selectivity, the choice of timer source, the entry levels of the pin, and the interplay of a clear pulse with an event in the same cycle.

// File: rtl/ccp_pkg.sv
package ccp_pkg;

  typedef enum logic [3:0] {
    K_OFF,
    K_CAP_FALL,
    K_CAP_RISE,
    K_CAP_DIV_A,
    K_CAP_DIV_B,
    K_CMP_TOGGLE,
    K_CMP_SET,
    K_CMP_CLR,
    K_CMP_FLAG,
    K_CMP_TRST
  } ccp_kind_e;

  function automatic ccp_kind_e ccp_decode(input logic [3:0] code);
    case (code)
      4'b0100: return K_CAP_FALL;
      4'b0101: return K_CAP_RISE;
      4'b0110: return K_CAP_DIV_A;
      4'b0111: return K_CAP_DIV_B;
      4'b0010: return K_CMP_TOGGLE;
      4'b1000: return K_CMP_SET;
      4'b1001: return K_CMP_CLR;
      4'b1010: return K_CMP_FLAG;
      4'b1011: return K_CMP_TRST;
      default: return K_OFF;
    endcase
  endfunction

  function automatic logic ccp_is_compare(input ccp_kind_e k);
    return (k == K_CMP_TOGGLE) || (k == K_CMP_SET) || (k == K_CMP_CLR) ||
           (k == K_CMP_FLAG) || (k == K_CMP_TRST);
  endfunction

endpackage

// File: rtl/ccp_sync_edge.sv
module ccp_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise,
  output logic fall
);
  // sh[STAGES-1] is the synchronised level, sh[STAGES] its previous value
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], pin};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
  assign fall = ~sh[STAGES-1] & sh[STAGES];

endmodule

// File: rtl/ccp_capture.sv
module ccp_capture
  import ccp_pkg::*;
#(
  parameter int TW    = 16,
  parameter int DIV_A = 4,
  parameter int DIV_B = 16,
  localparam int PRE_W = $clog2(DIV_B)
) (
  input  logic          clk,
  input  logic          rst,
  input  ccp_kind_e     kind,
  input  logic          mode_chg,
  input  logic          rise,
  input  logic          fall,
  input  logic [TW-1:0] timer,
  output logic [TW-1:0] cap_val,
  output logic          cap_evt
);
  localparam logic [PRE_W-1:0] LIM_A = PRE_W'(DIV_A - 1);
  localparam logic [PRE_W-1:0] LIM_B = PRE_W'(DIV_B - 1);

  logic [PRE_W-1:0] cnt;
  logic [PRE_W-1:0] limit;
  logic             qual;

  always_comb begin
    case (kind)
      K_CAP_DIV_A: limit = LIM_A;
      K_CAP_DIV_B: limit = LIM_B;
      default:     limit = '0;
    endcase
    qual = ((kind == K_CAP_FALL) && fall) ||
           (((kind == K_CAP_RISE) || (kind == K_CAP_DIV_A) ||
             (kind == K_CAP_DIV_B)) && rise);
    cap_evt = qual && !mode_chg && (cnt == limit);
  end

  always_ff @(posedge clk) begin
    if (rst || kind == K_OFF) begin
      cnt     <= '0;
      cap_val <= '0;
    end else if (mode_chg) begin
      cnt <= '0;
    end else if (qual) begin
      cnt <= (cnt == limit) ? '0 : cnt + PRE_W'(1);
      if (cap_evt) cap_val <= timer;
    end
  end

  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!cap_evt && kind != K_OFF) |=> $stable(cap_val)); // R4

endmodule

// File: rtl/ccp_compare.sv
module ccp_compare
  import ccp_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  ccp_kind_e     kind,
  input  logic          mode_chg,
  input  logic [TW-1:0] timer,
  input  logic [TW-1:0] cmp_val,
  output logic          match,
  output logic          out_pin,
  output logic          tmr_rst
);
  logic eq;
  logic eq_q;

  assign eq    = (timer == cmp_val);
  assign match = eq && !eq_q && !mode_chg && ccp_is_compare(kind);

  always_ff @(posedge clk) begin
    if (rst) eq_q <= 1'b0;
    else     eq_q <= eq;
  end

  always_ff @(posedge clk) begin
    if (rst || kind == K_OFF) begin
      out_pin <= 1'b0;
    end else if (mode_chg) begin
      if (kind == K_CMP_SET)      out_pin <= 1'b0;
      else if (kind == K_CMP_CLR) out_pin <= 1'b1;
    end else if (match) begin
      case (kind)
        K_CMP_TOGGLE: out_pin <= ~out_pin;
        K_CMP_SET:    out_pin <= 1'b1;
        K_CMP_CLR:    out_pin <= 1'b0;
        default:      out_pin <= out_pin;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) tmr_rst <= 1'b0;
    else     tmr_rst <= match && (kind == K_CMP_TRST);
  end

  AST_TRST_PULSE: assert property (@(posedge clk) disable iff (rst)
    tmr_rst |=> !tmr_rst); // R10
  AST_MATCH_ONCE: assert property (@(posedge clk) disable iff (rst)
    match |=> !match); // R11
  AST_SET_HIGH: assert property (@(posedge clk) disable iff (rst)
    (match && kind == K_CMP_SET) |=> out_pin); // R7
  AST_CLR_LOW: assert property (@(posedge clk) disable iff (rst)
    (match && kind == K_CMP_CLR) |=> !out_pin); // R8

endmodule

// File: rtl/ccp_unit.sv
module ccp_unit
  import ccp_pkg::*;
#(
  parameter int TW      = 16,
  parameter int NUM_TMR = 4,
  parameter int SYNC_N  = 2,
  parameter int DIV_A   = 4,
  parameter int DIV_B   = 16,
  localparam int SEL_W  = $clog2(NUM_TMR)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [3:0]            mode,
  input  logic [SEL_W-1:0]      tmr_sel,
  input  logic [NUM_TMR*TW-1:0] tmr_bus,
  input  logic [TW-1:0]         cmp_val,
  input  logic                  cap_pin,
  input  logic                  clr_flag,
  output logic [TW-1:0]         cap_val,
  output logic                  out_pin,
  output logic                  flag,
  output logic                  tmr_rst
);
  logic [TW-1:0] tmr_arr [NUM_TMR];
  logic [TW-1:0] timer;
  logic [3:0]    mode_q;
  logic          mode_chg;
  ccp_kind_e     kind;
  logic          rise, fall, cap_evt, cmp_match;

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    assign tmr_arr[i] = tmr_bus[i*TW +: TW];
  end
  assign timer = tmr_arr[tmr_sel];

  always_ff @(posedge clk) begin
    if (rst) mode_q <= 4'b0000;
    else     mode_q <= mode;
  end

  assign mode_chg = (mode != mode_q);
  assign kind     = ccp_decode(mode);

  ccp_sync_edge #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst(rst), .pin(cap_pin), .rise(rise), .fall(fall)
  );

  ccp_capture #(.TW(TW), .DIV_A(DIV_A), .DIV_B(DIV_B)) u_cap (
    .clk(clk), .rst(rst), .kind(kind), .mode_chg(mode_chg),
    .rise(rise), .fall(fall), .timer(timer),
    .cap_val(cap_val), .cap_evt(cap_evt)
  );

  ccp_compare #(.TW(TW)) u_cmp (
    .clk(clk), .rst(rst), .kind(kind), .mode_chg(mode_chg),
    .timer(timer), .cmp_val(cmp_val),
    .match(cmp_match), .out_pin(out_pin), .tmr_rst(tmr_rst)
  );

  always_ff @(posedge clk) begin
    if (rst || kind == K_OFF)     flag <= 1'b0;
    else if (cap_evt || cmp_match) flag <= 1'b1;
    else if (clr_flag)             flag <= 1'b0;
  end

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    (ccp_decode(mode_q) == K_OFF) |-> (!flag && !out_pin && cap_val == '0)); // R1
  AST_TRST_FLAG: assert property (@(posedge clk) disable iff (rst)
    tmr_rst |-> flag); // R10
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr_flag && kind != K_OFF) |=> flag); // R12

endmodule

// File: tb/ccp_unit_test.sv
module ccp_unit_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  mode;
  logic [1:0]  tmr_sel;
  logic [63:0] tmr_bus;
  logic [15:0] cmp_val;
  logic        cap_pin;
  logic        clr_flag;
  logic [15:0] cap_val;
  logic        out_pin, flag, tmr_rst;

  int vectors = 0;
  int misses  = 0;
  logic [15:0] exp_cap;
  logic        exp_pin, exp_flag;
  int          pc;

  always #5 clk = ~clk;

  ccp_unit uut (
    .clk(clk), .rst(rst), .mode(mode), .tmr_sel(tmr_sel), .tmr_bus(tmr_bus),
    .cmp_val(cmp_val), .cap_pin(cap_pin), .clr_flag(clr_flag),
    .cap_val(cap_val), .out_pin(out_pin), .flag(flag), .tmr_rst(tmr_rst)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    check(req, "cap_val", 32'(cap_val), 32'(exp_cap));
    check(req, "out_pin", 32'(out_pin), 32'(exp_pin));
    check(req, "flag",    32'(flag),    32'(exp_flag));
  endtask

  function automatic logic is_off(input logic [3:0] m);
    return (m == 4'd0) || (m == 4'd1) || (m == 4'd3) || (m[3:2] == 2'b11);
  endfunction

  task automatic set_tmr(input int idx, input logic [15:0] v);
    tmr_bus[idx*16 +: 16] = v;
  endtask

  task automatic enter(input logic [3:0] m);
    mode = m;
    tick();
    pc = 0;
    if (is_off(m)) begin
      exp_flag = 1'b0; exp_pin = 1'b0; exp_cap = '0;
    end else if (m == 4'b1000) exp_pin = 1'b0;
    else if (m == 4'b1001) exp_pin = 1'b1;
    tick();
  endtask

  task automatic clear_flag();
    clr_flag = 1'b1; tick(); clr_flag = 1'b0; tick();
    if (!is_off(mode)) exp_flag = 1'b0;
  endtask

  // rising-edge pulse under a divider of 'div' (0 = no capture on rise)
  task automatic pulse(input int div);
    cap_pin = 1'b1;
    repeat (4) tick();
    if (div > 0) begin
      pc++;
      if (pc == div) begin
        pc = 0; exp_cap = tmr_bus[tmr_sel*16 +: 16]; exp_flag = 1'b1;
      end
    end
    cap_pin = 1'b0;
    repeat (4) tick();
  endtask

  task automatic cmp_sweep(input logic [3:0] m, input logic [15:0] c,
                           input string req, input bit use_clr);
    logic [15:0] prev, v;
    logic        hit;
    tmr_sel = 2'd2;
    cmp_val = c;
    set_tmr(2, 16'd0);
    enter(m);
    check(req, "entry out_pin", 32'(out_pin), 32'(exp_pin));
    prev = 16'd0;
    for (int i = 0; i < 96; i++) begin
      v = 16'((i / 2) % 24);
      set_tmr(2, v);
      set_tmr(1, c);  // unselected source, must not match
      clr_flag = use_clr && (i % 7 == 3);
      tick();
      hit = (v == c) && (prev != c);
      if (hit) begin
        case (m)
          4'b0010: exp_pin = ~exp_pin;
          4'b1000: exp_pin = 1'b1;
          4'b1001: exp_pin = 1'b0;
          default: exp_pin = exp_pin;
        endcase
        exp_flag = 1'b1;
      end else if (clr_flag) exp_flag = 1'b0;
      check(req, "tmr_rst", 32'(tmr_rst), 32'(hit && m == 4'b1011));
      check_all(req);
      prev = v;
    end
    clr_flag = 1'b0;
    set_tmr(1, 16'd0);
  endtask

  initial begin
    #1_000_000;
    misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    rst = 1'b1; mode = 4'd0; tmr_sel = '0; tmr_bus = '0; cmp_val = '0;
    cap_pin = 1'b0; clr_flag = 1'b0;
    exp_cap = '0; exp_pin = 1'b0; exp_flag = 1'b0; pc = 0;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R1: reset state
    check_all("R1");
    check("R1", "tmr_rst", 32'(tmr_rst), 32'd0);

    // R1: every disabling code ignores pin edges and matches
    foreach (uut.mode[b]) ;
    for (int k = 0; k < 7; k++) begin
      logic [3:0] m;
      m = (k == 0) ? 4'd0 : (k == 1) ? 4'd1 : (k == 2) ? 4'd3 : 4'(12 + k - 3);
      enter(m);
      cmp_val = 16'h0040;
      set_tmr(0, 16'h0040);
      pulse(0);
      check_all("R1");
      check("R1", "tmr_rst", 32'(tmr_rst), 32'd0);
      set_tmr(0, 16'h0000);
    end

    // R3, R13: rising capture from each timer source
    enter(4'b0101);
    for (int s = 0; s < 4; s++) begin
      tmr_sel = 2'(s);
      for (int i = 0; i < 4; i++) set_tmr(i, 16'(16'hA000 + i * 257 + s * 17));
      pulse(1);
      check_all("R3 R13");
      // R12: clear pulse removes the flag
      clear_flag();
      check("R12", "flag after clear", 32'(flag), 32'd0);
    end

    // R2: falling capture ignores the rising edge
    enter(4'b0100);
    tmr_sel = 2'd3;
    set_tmr(3, 16'h1234);
    cap_pin = 1'b1; repeat (4) tick();
    check_all("R2 rise ignored");
    set_tmr(3, 16'h5678);
    cap_pin = 1'b0; repeat (4) tick();
    exp_cap = 16'h5678; exp_flag = 1'b1;
    check_all("R2 fall");
    clear_flag();

    // R4: divide by 4 then by 16
    tmr_sel = 2'd0;
    enter(4'b0110);
    for (int k = 1; k <= 8; k++) begin
      set_tmr(0, 16'(300 + k));
      pulse(4);
      check_all("R4 div4");
    end
    enter(4'b0111);
    for (int k = 1; k <= 32; k++) begin
      set_tmr(0, 16'(600 + k));
      pulse(16);
      check_all("R4 div16");
    end

    // R5: code change restarts the divider
    enter(4'b0110);
    for (int k = 1; k <= 2; k++) begin
      set_tmr(0, 16'(900 + k)); pulse(4); check_all("R5 pre");
    end
    enter(4'b0111);
    enter(4'b0110);
    for (int k = 1; k <= 4; k++) begin
      set_tmr(0, 16'(950 + k)); pulse(4); check_all("R5 post");
    end

    // R6..R11, R12 (set wins over clear), R13
    cmp_sweep(4'b0010, 16'd5,  "R6 R11 R12", 1'b1);
    cmp_sweep(4'b1000, 16'd9,  "R7 R11", 1'b0);
    cmp_sweep(4'b1001, 16'd13, "R8 R11", 1'b0);
    cmp_sweep(4'b1000, 16'd17, "R7 R13", 1'b0);
    cmp_sweep(4'b1010, 16'd7,  "R9 R11", 1'b1);
    cmp_sweep(4'b1011, 16'd20, "R10 R11", 1'b1);

    // R1: disabling after compare clears pin and flag
    enter(4'b1001);
    check("R8", "entry out_pin", 32'(out_pin), 32'd1);
    enter(4'b0000);
    check_all("R1 after compare");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule